// File: doc/BRIEF.md
# Reconfigurable-Depth Feed-Forward Processing Array

The block is a grid of small arithmetic cells arranged in rows. A vector of lanes enters the first row and moves downward, one row at a time, to the last row, whose lanes form the result vector. No path runs back up the grid or sideways within a row. Each cell picks its two operands from any lanes of the row above and applies one operation from a fixed set. Cells hold no state, so the grid as a whole is one large combinational function of its input vector.

Registers sit at a few fixed row boundaries. Each one can hold its row's data for a clock cycle or pass it straight through. These settings choose how many pipeline stages the grid has, and so set its latency and the clock rate it can reach. A valid bit travels next to the data through the same stages, so the result valid flag always matches the data it marks. Cell settings and stage settings are written through one word-wide port. That port refuses writes while any valid item is held inside a stage.

Top module: `vpa_array`

## Requirements
- R1: The default grid has 12 rows of 8 lanes, and each lane is 16 bits wide. Lane c of every vector sits at bits [16c+15:16c]. A cell computes from operands a and b according to its 3-bit operation code: 0 a+b, 1 a-b, 2 the low 16 bits of a*b, 3 a&b, 4 a|b, 5 a shifted left, 6 a shifted right (logical), 7 a unchanged.
- R2: For codes 5 and 6, the shift distance is bits [3:0] of b. The upper bits of b are ignored.
- R3: Operand a takes the lane selected by config bits [2:0], and operand b takes the lane selected by config bits [5:3]. Both select from the previous row's outputs. In row 0 they select from in_data_i.
- R4: A write to address r*8+c (below 96) loads the cell at row r, lane c with cfg_data_i[8:0]. Bits [8:6] hold the operation code.
- R5: A write to address 96 loads the stage register. Bit k set to 1 makes slot k register its data, and bit k set to 0 makes slot k pass its data through. Slot k sits below row ((k+1)*12)/8-1, which puts the slots under rows 0, 2, 3, 5, 6, 8 and 9.
- R6: The latency from in_data_i to out_data_o equals the number of slots in register mode. With every slot in pass-through mode, the output follows the input in the same cycle.
- R7: out_valid_o repeats in_valid_i delayed by the same latency as the data. No valid item is lost or duplicated, and bubbles are kept.
- R8: A write presented while any register-mode slot holds a valid item is discarded, and cfg_err_o is high for exactly the next cycle. A write presented when no valid item is held takes effect and leaves cfg_err_o low.
- R9: After reset no valid item is held, every slot is in pass-through mode, every cell holds code 0 with both selects at lane 0, and cfg_err_o is low.
- R10: A write to an address above 96 changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input vector valid |
| in_data_i | input | 128 | Input vector, 8 lanes of 16 bits |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Configuration address |
| cfg_data_i | input | 9 | Configuration write data |
| out_valid_o | output | 1 | Result vector valid |
| out_data_o | output | 128 | Result vector, 8 lanes of 16 bits |
| cfg_err_o | output | 1 | One-cycle pulse after a refused write |

## Verification
A wrong cell setting or a wrong operand select gives a wrong result lane on the first valid item after the setting is loaded. A stage slot stuck in the wrong mode moves out_valid_o earlier or later by a whole number of cycles, and the flag check catches this on the next isolated valid pulse. A wrong busy state shows up one cycle after a write, either as a wrong cfg_err_o or as a write that should have been refused but still changes later results. The reference model is compared on every cycle, so each of these faults is reported within the latency of the current stage setting.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_PASS = 3'd7
  } op_e;

  // row below which slot k is placed
  function automatic int slot_row(int rows, int nslot, int k);
    return ((k + 1) * rows) / (nslot + 1) - 1;
  endfunction

  // slot index placed below row r, or -1
  function automatic int slot_at(int rows, int nslot, int r);
    int hit;
    hit = -1;
    for (int k = 0; k < nslot; k++)
      if (slot_row(rows, nslot, k) == r) hit = k;
    return hit;
  endfunction

endpackage

// File: rtl/vpa_pe.sv
module vpa_pe
  import vpa_pkg::*;
#(
  parameter int COLS = 8,
  parameter int DW   = 16,
  parameter int SELW = $clog2(COLS),
  parameter int PCW  = 2 * SELW + 3
) (
  input  logic [COLS*DW-1:0] prev_i,
  input  logic [PCW-1:0]     cfg_i,
  output logic [DW-1:0]      res_o
);

  localparam int SHW = $clog2(DW);

  logic [SELW-1:0] sel_a, sel_b;
  logic [DW-1:0]   opa, opb;
  op_e             op;

  assign sel_a = cfg_i[SELW-1:0];
  assign sel_b = cfg_i[2*SELW-1:SELW];
  assign op    = op_e'(cfg_i[2*SELW+2:2*SELW]);
  assign opa   = prev_i[sel_a*DW +: DW];
  assign opb   = prev_i[sel_b*DW +: DW];

  always_comb begin
    unique case (op)
      OP_ADD:  res_o = opa + opb;
      OP_SUB:  res_o = opa - opb;
      OP_MUL:  res_o = opa * opb;
      OP_AND:  res_o = opa & opb;
      OP_OR:   res_o = opa | opb;
      OP_SHL:  res_o = opa << opb[SHW-1:0];
      OP_SHR:  res_o = opa >> opb[SHW-1:0];
      default: res_o = opa;
    endcase
  end

endmodule

// File: rtl/vpa_row.sv
module vpa_row #(
  parameter int COLS = 8,
  parameter int DW   = 16,
  parameter int SELW = $clog2(COLS),
  parameter int PCW  = 2 * SELW + 3
) (
  input  logic [COLS*DW-1:0]  prev_i,
  input  logic [COLS*PCW-1:0] cfg_i,
  output logic [COLS*DW-1:0]  res_o
);

  for (genvar c = 0; c < COLS; c++) begin : g_pe
    vpa_pe #(
      .COLS(COLS), .DW(DW), .SELW(SELW), .PCW(PCW)
    ) u_pe (
      .prev_i(prev_i),
      .cfg_i (cfg_i[c*PCW +: PCW]),
      .res_o (res_o[c*DW +: DW])
    );
  end

endmodule

// File: rtl/vpa_slot.sv
module vpa_slot #(
  parameter int VW = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          latch_i,
  input  logic          v_i,
  input  logic [VW-1:0] d_i,
  output logic          v_o,
  output logic [VW-1:0] d_o,
  output logic          held_o
);

  logic          q_v;
  logic [VW-1:0] q_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_v <= 1'b0;
      q_d <= '0;
    end else begin
      q_v <= latch_i & v_i;
      q_d <= d_i;
    end
  end

  assign v_o    = latch_i ? q_v : v_i;
  assign d_o    = latch_i ? q_d : d_i;
  assign held_o = latch_i & q_v;

endmodule

// File: rtl/vpa_cfg.sv
module vpa_cfg #(
  parameter int NPE   = 96,
  parameter int NSLOT = 7,
  parameter int PCW   = 9,
  parameter int AW    = 7,
  parameter int CW    = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [CW-1:0]      data_i,
  input  logic               idle_i,
  output logic [NPE*PCW-1:0] pe_cfg_o,
  output logic [NSLOT-1:0]   latch_o,
  output logic               err_o
);

  logic wr_ok;
  assign wr_ok = we_i & idle_i;

  for (genvar gi = 0; gi < NPE; gi++) begin : g_pe
    logic [PCW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= '0;
      else if (wr_ok && addr_i == AW'(gi))      q <= data_i[PCW-1:0];
    end
    assign pe_cfg_o[gi*PCW +: PCW] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= we_i & ~idle_i;
      if (wr_ok && addr_i == AW'(NPE)) latch_o <= data_i[NSLOT-1:0];
    end
  end

endmodule

// File: rtl/vpa_array.sv
module vpa_array
  import vpa_pkg::*;
#(
  parameter int ROWS  = 12,
  parameter int COLS  = 8,
  parameter int DW    = 16,
  parameter int NSLOT = 7,
  localparam int SELW = $clog2(COLS),
  localparam int PCW  = 2 * SELW + 3,
  localparam int NPE  = ROWS * COLS,
  localparam int AW   = $clog2(NPE + 1),
  localparam int CW   = (PCW > NSLOT) ? PCW : NSLOT,
  localparam int VW   = COLS * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [VW-1:0] in_data_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [CW-1:0] cfg_data_i,
  output logic          out_valid_o,
  output logic [VW-1:0] out_data_o,
  output logic          cfg_err_o
);

  logic [NPE*PCW-1:0] pe_cfg;
  logic [NSLOT-1:0]   slot_latch;
  logic [NSLOT-1:0]   slot_held;
  logic               idle;

  logic [VW-1:0]      row_in  [ROWS];
  logic [VW-1:0]      row_out [ROWS];
  logic [ROWS-1:0]    v_in;

  assign idle = ~|slot_held;

  vpa_cfg #(
    .NPE(NPE), .NSLOT(NSLOT), .PCW(PCW), .AW(AW), .CW(CW)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .data_i  (cfg_data_i),
    .idle_i  (idle),
    .pe_cfg_o(pe_cfg),
    .latch_o (slot_latch),
    .err_o   (cfg_err_o)
  );

  assign row_in[0] = in_data_i;
  assign v_in[0]   = in_valid_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    vpa_row #(
      .COLS(COLS), .DW(DW), .SELW(SELW), .PCW(PCW)
    ) u_row (
      .prev_i(row_in[r]),
      .cfg_i (pe_cfg[r*COLS*PCW +: COLS*PCW]),
      .res_o (row_out[r])
    );
  end

  for (genvar r = 1; r < ROWS; r++) begin : g_link
    localparam int SK = slot_at(ROWS, NSLOT, r - 1);
    if (SK >= 0) begin : g_slot
      vpa_slot #(.VW(VW)) u_slot (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .latch_i(slot_latch[SK]),
        .v_i    (v_in[r-1]),
        .d_i    (row_out[r-1]),
        .v_o    (v_in[r]),
        .d_o    (row_in[r]),
        .held_o (slot_held[SK])
      );
    end else begin : g_wire
      assign v_in[r]   = v_in[r-1];
      assign row_in[r] = row_out[r-1];
    end
  end

  assign out_data_o  = row_out[ROWS-1];
  assign out_valid_o = v_in[ROWS-1];

endmodule

// File: rtl/vpa_array_chk.sv
module vpa_array_chk #(
  parameter int NSLOT = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic             cfg_err_o,
  input logic [NSLOT-1:0] slot_latch_i,
  input logic [NSLOT-1:0] slot_held_i
);

  // R8: a write while items are held is refused and flagged
  a_r8_err_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && slot_held_i != '0) |=> cfg_err_o);

  // R8: no flag without a refused write
  a_r8_no_spurious_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && slot_held_i != '0) |=> !cfg_err_o);

  // R8: stage settings stay frozen while items are held
  a_r8_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_held_i != '0) |=> $stable(slot_latch_i));

  // R6: all pass-through means valid flows in the same cycle
  a_r6_bypass_flow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_latch_i == '0) |-> (out_valid_o == in_valid_i));

  // R7: with any stage registered, an output item must come from a held one
  a_r7_out_from_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && slot_latch_i != '0) |-> (slot_held_i != '0));

endmodule

bind vpa_array vpa_array_chk #(.NSLOT(NSLOT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .cfg_err_o   (cfg_err_o),
  .slot_latch_i(slot_latch),
  .slot_held_i (slot_held)
);

// File: tb/vpa_array_bench.sv
`timescale 1ns/1ps
module vpa_array_bench;
  localparam int ROWS = 12, COLS = 8, DW = 16, NSLOT = 7;
  localparam int NPE = ROWS * COLS, AW = 7, CW = 9, VW = COLS * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_data = '0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;
  logic          cfg_err;

  always #4 clk = ~clk;

  vpa_array u_vpa_array (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .cfg_err_o(cfg_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  // reference model state
  int            m_op [ROWS][COLS];
  int            m_sa [ROWS][COLS];
  int            m_sb [ROWS][COLS];
  bit            m_lat [NSLOT];
  bit            hv [NSLOT+1];
  logic [VW-1:0] hd [NSLOT+1];
  bit            m_err;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [VW-1:0] rvec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = rnd();
    return v;
  endfunction

  task automatic model_reset();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        m_op[r][c] = 0; m_sa[r][c] = 0; m_sb[r][c] = 0;
      end
    for (int k = 0; k < NSLOT; k++) m_lat[k] = 0;
    for (int i = 0; i <= NSLOT; i++) begin hv[i] = 0; hd[i] = '0; end
    m_err = 0;
  endtask

  function automatic int lat_count();
    int n = 0;
    for (int k = 0; k < NSLOT; k++) n += m_lat[k];
    return n;
  endfunction

  function automatic logic [VW-1:0] run(input logic [VW-1:0] x);
    logic [VW-1:0] cur, nxt;
    logic [DW-1:0] a, b, r;
    logic [31:0]   p;
    cur = x;
    for (int row = 0; row < ROWS; row++) begin
      for (int c = 0; c < COLS; c++) begin
        a = cur[m_sa[row][c]*DW +: DW];
        b = cur[m_sb[row][c]*DW +: DW];
        case (m_op[row][c])
          0: r = a + b;
          1: r = a - b;
          2: begin p = {16'd0, a} * {16'd0, b}; r = p[15:0]; end
          3: r = a & b;
          4: r = a | b;
          5: r = a << b[3:0];
          6: r = a >> b[3:0];
          default: r = a;
        endcase
        nxt[c*DW +: DW] = r;
      end
      cur = nxt;
    end
    return cur;
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit busy;
      int n;
      busy = 0;
      n = lat_count();
      for (int k = 0; k < n; k++) busy |= hv[k];
      m_err = cfg_we && busy;
      for (int i = NSLOT; i > 0; i--) begin hv[i] = hv[i-1]; hd[i] = hd[i-1]; end
      hv[0] = in_valid;
      hd[0] = run(in_data);
      if (cfg_we && !busy) begin
        if (int'(cfg_addr) < NPE) begin
          m_sa[cfg_addr/COLS][cfg_addr%COLS] = int'(cfg_data[2:0]);
          m_sb[cfg_addr/COLS][cfg_addr%COLS] = int'(cfg_data[5:3]);
          m_op[cfg_addr/COLS][cfg_addr%COLS] = int'(cfg_data[8:6]);
        end else if (int'(cfg_addr) == NPE) begin
          for (int k = 0; k < NSLOT; k++) m_lat[k] = cfg_data[k];
          for (int i = 0; i <= NSLOT; i++) hv[i] = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [VW-1:0] d, input bit we = 0,
                     input logic [AW-1:0] a = '0, input logic [CW-1:0] wd = '0,
                     input string tag = "R6/R7");
    int n;
    bit ev;
    logic [VW-1:0] ed;
    @(negedge clk);
    in_valid = v; in_data = d; cfg_we = we; cfg_addr = a; cfg_data = wd;
    #2;
    n  = lat_count();
    ev = (n == 0) ? in_valid : hv[n-1];
    ed = (n == 0) ? run(in_data) : hd[n-1];
    chk({tag, " valid"}, VW'(out_valid), VW'(ev));
    if (ev) chk({tag, " R1/R2/R3 data"}, out_data, ed);
    chk("R8 err flag", VW'(cfg_err), VW'(m_err));
  endtask

  task automatic stream(input int n, input int pct, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r;
      r = rnd();
      cyc(int'(r % 100) < pct, rvec(), 0, '0, '0, tag);
    end
  endtask

  task automatic set_mode(input logic [NSLOT-1:0] m);
    cyc(0, '0, 1, AW'(NPE), CW'(m), "R5");
  endtask

  initial begin
    // reset state, R9
    repeat (3) @(negedge clk);
    #2;
    chk("R9 reset valid", VW'(out_valid), '0);
    chk("R9 reset err", VW'(cfg_err), '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: default cells ADD lane0, all pass-through
    for (int i = 0; i < 4; i++) cyc(1, rvec(), 0, '0, '0, "R9 default");
    // R4: program all cells
    for (int i = 0; i < NPE; i++) begin
      logic [31:0] r;
      r = rnd();
      cyc(0, '0, 1, AW'(i), r[8:0], "R4");
    end
    stream(24, 80, "R6 bypass");
    // R5/R6/R7: several stage patterns
    set_mode(7'h7F); stream(30, 60, "R6/R7 full"); stream(9, 0, "R7 drain");
    set_mode(7'h15); stream(30, 50, "R6/R7 three"); stream(5, 0, "R7 drain");
    set_mode(7'h40); stream(20, 70, "R6/R7 one");   stream(3, 0, "R7 drain");
    // R8: refused writes while busy (L=3)
    set_mode(7'h15);
    cyc(1, rvec(), 0, '0, '0, "R8");
    cyc(0, '0, 1, AW'(5), 9'h1C0, "R8 busy cell");
    cyc(1, rvec(), 0, '0, '0, "R8");
    cyc(0, '0, 1, AW'(NPE), 9'h000, "R8 busy mode");
    stream(6, 0, "R8 drain");
    cyc(1, rvec(), 0, '0, '0, "R8");
    stream(5, 0, "R8 drain");
    cyc(0, '0, 1, AW'(5), 9'h1C0, "R8 idle write");
    cyc(1, rvec(), 0, '0, '0, "R8");
    stream(5, 0, "R8 drain");
    // R10: out-of-map write ignored
    cyc(0, '0, 1, AW'(NPE + 1), 9'h1FF, "R10");
    cyc(0, '0, 1, AW'(127), 9'h07F, "R10");
    stream(20, 60, "R10 after");
    stream(5, 0, "R10 drain");
    // new cell set, R2 shifts with random high bits
    for (int i = 0; i < NPE; i++) begin
      logic [31:0] r;
      r = rnd();
      cyc(0, '0, 1, AW'(i), {r[0] ? 3'd5 : 3'd6, r[5:0]}, "R2 cfg");
    end
    set_mode(7'h00);
    stream(20, 90, "R2 shifts");
    set_mode(7'h2A);
    stream(20, 90, "R2 shifts piped");
    stream(5, 0, "R7 drain");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule